// File: doc/BRIEF.md
# Boot Mode Sampling Controller

This block governs how execution starts after a reset release or after the device leaves standby. It counts rising edges of the system clock. On a fixed edge it captures two boot-select inputs and turns them into a boot-mode code. It then frees the boot-select pin that is shared with general-purpose logic.

After an optional start-up wait it issues two fetches through a valid/acknowledge handshake:
- the initial stack pointer, at byte address 0;
- the entry point, at byte address 4.

Once both fetches are acknowledged, the core is allowed to run. The memory that answers the fetches, and the mapping of a memory into the code space, sit outside this block.

One boot input is a dedicated pin. The other is shared. While the shared pin is being sampled it belongs to the boot logic, and the pin-release flag tells the pin multiplexer when it may hand the pin back. The mode code stays constant between samples, so later activity on either pin has no effect.

Top module: `boot_seq`

## Requirements
- R1: While `rst_n` is low, `pin_release`, `fetch_valid` and `core_run` are 0 and `boot_mode` is 0.
- R2: The boot inputs are captured on the 4th rising clock edge after reset release or standby exit (`SAMPLE_EDGE` = 4). `pin_release` is 0 after the 3rd such edge and 1 after the 4th.
- R3: The mode code depends on the two pins:
  - `boot_ded` = 0 gives `boot_mode` = 0 (main code memory), whatever the value of `boot_shr`;
  - `boot_ded` = 1 with `boot_shr` = 0 gives 1 (system memory);
  - `boot_ded` = 1 with `boot_shr` = 1 gives 2 (on-chip RAM);
  - code 3 never appears.
- R4: Changes on `boot_ded` or `boot_shr` after the sampling edge leave `boot_mode` unchanged until the next sample.
- R5: While `standby` is high, `pin_release`, `fetch_valid` and `core_run` go to 0 one edge later and `boot_mode` keeps its last sampled value.
- R6: When `standby` falls, the pins are sampled again on the 4th following edge and `boot_mode` takes the new code.
- R7: `start_delay` is captured on the sampling edge. `fetch_valid` first rises exactly that many cycles after the sampling edge, which means directly after it when the value is 0.
- R8: The first fetch presents `fetch_addr` = 0 and holds `fetch_valid` and the address steady until `fetch_ack` is seen.
- R9: After the first acknowledge, the second fetch presents `fetch_addr` = 4 and is held the same way until its acknowledge.
- R10: `core_run` rises on the edge that accepts the second acknowledge, at which point `fetch_valid` drops. `core_run` is never high before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | High while the device is in standby |
| boot_ded | input | 1 | Dedicated boot-select pin |
| boot_shr | input | 1 | Boot-select pin shared with general-purpose use |
| start_delay | input | DW | Start-up wait in cycles before the first fetch |
| boot_mode | output | 2 | Latched boot-mode code |
| pin_release | output | 1 | Shared pin is free for general use |
| fetch_addr | output | AW | Byte address of the current start-up fetch |
| fetch_valid | output | 1 | Start-up fetch request |
| fetch_ack | input | 1 | Acknowledge for the current fetch |
| core_run | output | 1 | Core may execute |

## Verification
The bench keeps the default widths (`AW` = 32, `DW` = 8) and `SAMPLE_EDGE` = 4. With these values, every sequence stays within about twenty cycles, so a full sweep is affordable.

The sweep covers:
- all four pin combinations;
- start-up waits of 0, 1, 2 and 5;
- acknowledge latencies of 0 to 2 cycles;
- every case entered both from reset and from standby exit.

This brings within reach the duplicated encoding, the zero-wait bypass, back-to-back acknowledges, and resampling into a different mode than the one held before.

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int SAMPLE_EDGE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          boot_ded,
  input  logic          boot_shr,
  input  logic [DW-1:0] start_delay,
  output logic [1:0]    boot_mode,
  output logic          pin_release,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_valid,
  input  logic          fetch_ack,
  output logic          core_run
);
  localparam int CW = $clog2(SAMPLE_EDGE + 1);

  typedef enum logic [2:0] {S_CNT, S_DLY, S_SP, S_PC, S_RUN} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dcnt, dly_q;
  logic [1:0] enc;

  assign enc = boot_ded ? (boot_shr ? 2'd2 : 2'd1) : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_CNT;
      cnt       <= '0;
      dcnt      <= '0;
      dly_q     <= '0;
      boot_mode <= 2'd0;
    end else if (standby) begin
      st  <= S_CNT;
      cnt <= '0;
    end else begin
      case (st)
        S_CNT:
          if (cnt == CW'(SAMPLE_EDGE - 1)) begin
            boot_mode <= enc;
            dly_q     <= start_delay;
            dcnt      <= '0;
            cnt       <= '0;
            st        <= (start_delay == '0) ? S_SP : S_DLY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_DLY:
          if (dcnt == dly_q - DW'(1)) st <= S_SP;
          else dcnt <= dcnt + 1'b1;
        S_SP: if (fetch_ack) st <= S_PC;
        S_PC: if (fetch_ack) st <= S_RUN;
        default: ;
      endcase
    end
  end

  assign pin_release = (st != S_CNT);
  assign fetch_valid = (st == S_SP) || (st == S_PC);
  assign fetch_addr  = (st == S_PC) ? AW'(4) : AW'(0);
  assign core_run    = (st == S_RUN);
endmodule

module boot_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic [1:0]    boot_mode,
  input logic          pin_release,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_valid,
  input logic          fetch_ack,
  input logic          core_run
);
  // R3
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_mode != 2'b11);
  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_release && !standby) |=> (!pin_release || $stable(boot_mode)));
  // R5
  standby_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!pin_release && !core_run && !fetch_valid));
  // R8
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ack && !standby) |=> (fetch_valid && $stable(fetch_addr)));
  // R9
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_addr == AW'(0) || fetch_addr == AW'(4)));
  // R10
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> $past(fetch_valid && fetch_ack && fetch_addr == AW'(4)));
  // R10
  run_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> (pin_release && !fetch_valid));
endmodule

bind boot_seq boot_seq_chk #(.AW(AW)) chk (.*);

// File: tb/boot_seq_test.sv
module boot_seq_test;
  logic clk = 0, rst_n = 0, standby = 0, boot_ded = 0, boot_shr = 0, fetch_ack = 0;
  logic [7:0] start_delay = 0;
  logic [1:0] boot_mode;
  logic pin_release, fetch_valid, core_run;
  logic [31:0] fetch_addr;
  int tests = 0, fails = 0;
  logic [1:0] held = 0;

  always #2.5 clk = ~clk;

  boot_seq uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code(input bit d, input bit s);
    return d ? (s ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  task automatic run(input bit via_sb, input bit d, input bit s, input int dly, input int lat);
    @(negedge clk);
    boot_ded = d; boot_shr = s; start_delay = 8'(dly);
    if (via_sb) begin
      standby = 1;
      repeat (2) @(negedge clk);
      chk(!pin_release && !core_run && !fetch_valid, "R5 standby outputs", pin_release, 0);
      chk(boot_mode == held, "R5 mode retained", boot_mode, held);
      standby = 0;
    end else begin
      rst_n = 0;
      #1;
      chk(!pin_release && !fetch_valid && !core_run && boot_mode == 0, "R1 reset state", boot_mode, 0);
      @(negedge clk);
      rst_n = 1;
    end
    repeat (3) @(negedge clk);
    chk(!pin_release, via_sb ? "R6 no release before edge 4" : "R2 no release before edge 4", pin_release, 0);
    @(negedge clk);
    chk(pin_release, "R2 release after edge 4", pin_release, 1);
    chk(boot_mode == code(d, s), via_sb ? "R6 resampled mode" : "R3 mode code", boot_mode, code(d, s));
    held = code(d, s);
    boot_ded = ~d; boot_shr = ~s;
    chk(fetch_valid == (dly == 0), "R7 valid at sample edge", fetch_valid, dly == 0);
    if (dly > 0) begin
      repeat (dly - 1) @(negedge clk);
      chk(!fetch_valid, "R7 still waiting", fetch_valid, 0);
      @(negedge clk);
    end
    chk(fetch_valid && fetch_addr == 0, "R7 first fetch after wait", fetch_addr, 0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(fetch_valid && fetch_addr == 0 && !core_run, "R8 first fetch held", fetch_addr, 0);
    end
    fetch_ack = 1; @(negedge clk); fetch_ack = 0;
    chk(fetch_valid && fetch_addr == 4 && !core_run, "R9 second fetch", fetch_addr, 4);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(fetch_valid && fetch_addr == 4 && !core_run, "R9 second fetch held", fetch_addr, 4);
    end
    fetch_ack = 1; @(negedge clk); fetch_ack = 0;
    chk(core_run && !fetch_valid, "R10 run after second ack", core_run, 1);
    repeat (2) @(negedge clk);
    chk(boot_mode == held && pin_release, "R4 pins ignored after sample", boot_mode, held);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int sb = 0; sb < 2; sb++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++)
          for (int lat = 0; lat < 3; lat++)
            run(sb[0], p[0], p[1], (k == 3) ? 5 : k, lat);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule